// File: doc/BRIEF.md
# Virtually Indexed, Physically Tagged L1 Data Cache Lookup

This block is the lookup path of a set-associative level-one data cache whose set index and byte offset both sit inside the page offset of the address. A request carries only the untranslated page-offset bits. The block starts the set read in the same cycle it accepts the request. The physical page number comes from the translation buffer in that cycle or in any later one. Once it is present, the block compares it with the stored tags of every way in the selected set.

A hit returns the way and one data byte, or stores one byte when the access is a write. A miss selects a victim way and issues a line request to the next memory level. If the victim holds modified data, the block hands that line out in the same cycle. When the returned line arrives, the block installs it and answers the original access. Writes are write-back and write-allocate, with a dirty flag per line. Replacement is least recently used within each set.

With default parameters, the cache has 64 sets of 64-byte lines in 8 ways, which is 32 KB. The stored tag is the full 40-bit physical page number.

Top module: `vipt_l1_lookup`

## Requirements
- R1: After reset, `req_ready` is 1 and `resp_valid`, `fill_req_valid` and `evict_valid` are 0. Every line is invalid, so the first access to any set misses.
- R2: A request is taken when `req_valid` and `req_ready` are both 1. The set index is `req_offset[11:6]` and the byte number in the line is `req_offset[5:0]`. `req_ready` stays 0 from the cycle after acceptance until the cycle in which the response is shown.
- R3: The page number may be strobed with `ppn_valid` in the acceptance cycle or in any later cycle. Until it arrives, no response and no line request is produced. The compare happens in the first cycle that is at least one cycle after acceptance and has the page number available. A hit response appears in the next cycle.
- R4: A hit means a valid way whose stored tag equals the page number. It gives `resp_hit`=1, `resp_way` set to that way, and `resp_data` set to the addressed byte.
- R5: On a miss, `fill_req_valid` pulses for one cycle, in the cycle after the compare. `fill_req_line` is `{ppn, set index}`, with the set index in the low 6 bits.
- R6: The cycle after `fill_valid` is seen during an outstanding miss, the block installs `fill_data` into the victim way. Byte k of a line is at bits [8k+7:8k]. The response then shows `resp_hit`=0, the victim way, and the addressed byte. A later access to the same line hits.
- R7: A write stores `req_wdata` into the addressed byte, on a hit or after the fill on a miss, and marks the line dirty. Its response data is the written byte, and later reads return that byte.
- R8: On a miss, the victim is the lowest-numbered invalid way of the set. If no way is invalid, it is the way least recently hit or filled.
- R9: When the victim is valid and dirty, `evict_valid` is 1 in the same cycle as `fill_req_valid`. `evict_line` is `{old tag, set index}` and `evict_data` is the line's current contents. A clean or invalid victim gives `evict_valid`=0.
- R10: `fill_valid` while no miss is outstanding changes no line and gives no response. `ppn_valid` while no request is being accepted or pending is not used by a later request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request strobe |
| req_ready | output | 1 | Block can take a request |
| req_offset | input | 12 | Page-offset bits of the virtual address |
| req_write | input | 1 | 1 = byte write, 0 = byte read |
| req_wdata | input | 8 | Byte to write |
| ppn_valid | input | 1 | Page number strobe from translation |
| ppn | input | 40 | Physical page number |
| resp_valid | output | 1 | Response strobe, one cycle |
| resp_hit | output | 1 | Access hit in the cache |
| resp_way | output | 3 | Way that served the access |
| resp_data | output | 8 | Addressed byte (written byte for writes) |
| fill_req_valid | output | 1 | Line request to next level, one cycle |
| fill_req_line | output | 46 | Physical line address requested |
| evict_valid | output | 1 | Dirty victim write-back strobe |
| evict_line | output | 46 | Physical line address of the victim |
| evict_data | output | 512 | Victim line contents |
| fill_valid | input | 1 | Requested line is returned |
| fill_data | input | 512 | Returned line contents |

## Verification
A miss whose least recently used victim is dirty triggers two actions in one cycle: the fill request for the new line and the write-back of the displaced line. To provoke this, the bench writes a byte into a line, fills the other seven ways of the same set, and then misses once more in that set. In the cycle where `fill_req_valid` shows, the bench checks that `evict_valid` is also 1, that the evicted address is the old page, and that the evicted data is the fetched line with the written byte in place. The next miss in the set picks a clean victim, and the bench then expects the write-back strobe to stay low while the fill request fires.

// File: rtl/vipt_pkg.sv
`timescale 1ns/1ps
package vipt_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_TAG  = 2'd1,
    ST_FILL = 2'd2
  } vipt_state_e;

endpackage

// File: rtl/vipt_way_ram.sv
`timescale 1ns/1ps
// One way of the cache: tag array and line array, synchronous read, one write port.
module vipt_way_ram #(
  parameter int IDX_W  = 6,
  parameter int TAG_W  = 40,
  parameter int LINE_W = 512
) (
  input  logic              clk,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic              we,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [LINE_W-1:0] wr_line,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [LINE_W-1:0] rd_line
);
  localparam int SETS = 1 << IDX_W;

  logic [TAG_W-1:0]  tag_mem  [SETS];
  logic [LINE_W-1:0] line_mem [SETS];

  always_ff @(posedge clk) begin
    if (we) begin
      tag_mem[wr_idx]  <= wr_tag;
      line_mem[wr_idx] <= wr_line;
    end
    rd_tag  <= tag_mem[rd_idx];
    rd_line <= line_mem[rd_idx];
  end
endmodule

// File: rtl/vipt_lru_ages.sv
`timescale 1ns/1ps
// Per-set age counters: 0 = most recent, WAYS-1 = least recent.
module vipt_lru_ages #(
  parameter int SETS  = 64,
  parameter int WAYS  = 8,
  parameter int SET_W = 6,
  parameter int WAY_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SET_W-1:0] look_set,
  output logic [WAY_W-1:0] oldest_way,
  input  logic             touch_en,
  input  logic [SET_W-1:0] touch_set,
  input  logic [WAY_W-1:0] touch_way
);
  logic [WAY_W-1:0] age_q [SETS][WAYS];
  logic [WAY_W-1:0] touched_age;

  assign touched_age = age_q[touch_set][touch_way];

  always_comb begin
    oldest_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (age_q[look_set][w] == WAY_W'(WAYS - 1)) oldest_way = WAY_W'(w);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) begin
        for (int w = 0; w < WAYS; w++) age_q[s][w] <= WAY_W'(w);
      end
    end else if (touch_en) begin
      for (int w = 0; w < WAYS; w++) begin
        if (WAY_W'(w) == touch_way)
          age_q[touch_set][w] <= '0;
        else if (age_q[touch_set][w] < touched_age)
          age_q[touch_set][w] <= age_q[touch_set][w] + 1'b1;
      end
    end
  end
endmodule

// File: rtl/vipt_l1_lookup.sv
`timescale 1ns/1ps
module vipt_l1_lookup
  import vipt_pkg::*;
#(
  parameter int PPN_W   = 40,
  parameter int PGOFF_W = 12,
  parameter int OFF_W   = 6,
  parameter int WAYS    = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          req_valid,
  output logic                          req_ready,
  input  logic [PGOFF_W-1:0]            req_offset,
  input  logic                          req_write,
  input  logic [BYTE_W-1:0]             req_wdata,
  input  logic                          ppn_valid,
  input  logic [PPN_W-1:0]              ppn,
  output logic                          resp_valid,
  output logic                          resp_hit,
  output logic [$clog2(WAYS)-1:0]       resp_way,
  output logic [BYTE_W-1:0]             resp_data,
  output logic                          fill_req_valid,
  output logic [PPN_W+PGOFF_W-OFF_W-1:0] fill_req_line,
  output logic                          evict_valid,
  output logic [PPN_W+PGOFF_W-OFF_W-1:0] evict_line,
  output logic [(BYTE_W<<OFF_W)-1:0]    evict_data,
  input  logic                          fill_valid,
  input  logic [(BYTE_W<<OFF_W)-1:0]    fill_data
);
  localparam int IDX_W  = PGOFF_W - OFF_W;
  localparam int SETS   = 1 << IDX_W;
  localparam int LINE_W = BYTE_W << OFF_W;
  localparam int WAY_W  = $clog2(WAYS);
  localparam int BIT_W  = OFF_W + 3;

  vipt_state_e        state_q;
  logic [IDX_W-1:0]   idx_q;
  logic [OFF_W-1:0]   boff_q;
  logic               wr_q;
  logic [BYTE_W-1:0]  wdata_q;
  logic [PPN_W-1:0]   ppn_q;
  logic               ppn_have_q;
  logic [WAY_W-1:0]   victim_q;
  logic [WAYS-1:0]    valid_q [SETS];
  logic [WAYS-1:0]    dirty_q [SETS];

  logic [IDX_W-1:0]   rd_idx;
  logic [PPN_W-1:0]   rd_tag  [WAYS];
  logic [LINE_W-1:0]  rd_line [WAYS];
  logic [WAYS-1:0]    way_we;
  logic [PPN_W-1:0]   wr_tag;
  logic [LINE_W-1:0]  wr_line;

  logic               ppn_ok;
  logic [PPN_W-1:0]   lookup_ppn;
  logic [WAYS-1:0]    hit_vec;
  logic [WAYS-1:0]    inv_vec;
  logic [WAY_W-1:0]   hit_way;
  logic [WAY_W-1:0]   inv_way;
  logic [WAY_W-1:0]   lru_way;
  logic [WAY_W-1:0]   victim;
  logic [LINE_W-1:0]  hit_line;
  logic [LINE_W-1:0]  hit_merged;
  logic [LINE_W-1:0]  fill_merged;
  logic [BIT_W-1:0]   bit_pos;
  logic               tag_cycle;
  logic               tag_hit;
  logic               fill_done;
  logic               touch_en;
  logic [WAY_W-1:0]   touch_way;

  assign req_ready  = (state_q == ST_IDLE);
  // Set read starts from the untranslated offset while idle.
  assign rd_idx     = (state_q == ST_IDLE) ? req_offset[PGOFF_W-1:OFF_W] : idx_q;
  assign ppn_ok     = ppn_have_q | ppn_valid;
  assign lookup_ppn = ppn_have_q ? ppn_q : ppn;
  assign bit_pos    = {boff_q, 3'b000};
  assign tag_cycle  = (state_q == ST_TAG) && ppn_ok;
  assign tag_hit    = tag_cycle && (|hit_vec);
  assign fill_done  = (state_q == ST_FILL) && fill_valid;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign hit_vec[w] = valid_q[idx_q][w] && (rd_tag[w] == lookup_ppn);
    assign inv_vec[w] = !valid_q[idx_q][w];
    assign way_we[w]  = (tag_hit && wr_q && (hit_way == WAY_W'(w))) ||
                        (fill_done && (victim_q == WAY_W'(w)));
    vipt_way_ram #(
      .IDX_W (IDX_W),
      .TAG_W (PPN_W),
      .LINE_W(LINE_W)
    ) u_way_ram (
      .clk    (clk),
      .rd_idx (rd_idx),
      .we     (way_we[w]),
      .wr_idx (idx_q),
      .wr_tag (wr_tag),
      .wr_line(wr_line),
      .rd_tag (rd_tag[w]),
      .rd_line(rd_line[w])
    );
  end

  always_comb begin
    hit_way = '0;
    inv_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (hit_vec[w]) hit_way = WAY_W'(w);
      if (inv_vec[w]) inv_way = WAY_W'(w);
    end
  end

  assign touch_en  = tag_hit || fill_done;
  assign touch_way = tag_hit ? hit_way : victim_q;

  vipt_lru_ages #(
    .SETS (SETS),
    .WAYS (WAYS),
    .SET_W(IDX_W),
    .WAY_W(WAY_W)
  ) u_lru (
    .clk       (clk),
    .rst       (rst),
    .look_set  (idx_q),
    .oldest_way(lru_way),
    .touch_en  (touch_en),
    .touch_set (idx_q),
    .touch_way (touch_way)
  );

  assign victim   = (|inv_vec) ? inv_way : lru_way;
  assign hit_line = rd_line[hit_way];

  always_comb begin
    hit_merged = hit_line;
    hit_merged[bit_pos +: BYTE_W] = wdata_q;
    fill_merged = fill_data;
    if (wr_q) fill_merged[bit_pos +: BYTE_W] = wdata_q;
  end

  assign wr_tag  = (state_q == ST_TAG) ? lookup_ppn : ppn_q;
  assign wr_line = (state_q == ST_TAG) ? hit_merged : fill_merged;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q        <= ST_IDLE;
      idx_q          <= '0;
      boff_q         <= '0;
      wr_q           <= 1'b0;
      wdata_q        <= '0;
      ppn_q          <= '0;
      ppn_have_q     <= 1'b0;
      victim_q       <= '0;
      resp_valid     <= 1'b0;
      resp_hit       <= 1'b0;
      resp_way       <= '0;
      resp_data      <= '0;
      fill_req_valid <= 1'b0;
      fill_req_line  <= '0;
      evict_valid    <= 1'b0;
      evict_line     <= '0;
      evict_data     <= '0;
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= '0;
        dirty_q[s] <= '0;
      end
    end else begin
      resp_valid     <= 1'b0;
      fill_req_valid <= 1'b0;
      evict_valid    <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            idx_q      <= req_offset[PGOFF_W-1:OFF_W];
            boff_q     <= req_offset[OFF_W-1:0];
            wr_q       <= req_write;
            wdata_q    <= req_wdata;
            ppn_have_q <= ppn_valid;
            ppn_q      <= ppn;
            state_q    <= ST_TAG;
          end
        end
        ST_TAG: begin
          if (ppn_ok) begin
            ppn_q      <= lookup_ppn;
            ppn_have_q <= 1'b0;
            if (|hit_vec) begin
              resp_valid <= 1'b1;
              resp_hit   <= 1'b1;
              resp_way   <= hit_way;
              resp_data  <= wr_q ? wdata_q : hit_line[bit_pos +: BYTE_W];
              if (wr_q) dirty_q[idx_q][hit_way] <= 1'b1;
              state_q    <= ST_IDLE;
            end else begin
              victim_q       <= victim;
              fill_req_valid <= 1'b1;
              fill_req_line  <= {lookup_ppn, idx_q};
              evict_valid    <= valid_q[idx_q][victim] && dirty_q[idx_q][victim];
              evict_line     <= {rd_tag[victim], idx_q};
              evict_data     <= rd_line[victim];
              state_q        <= ST_FILL;
            end
          end
        end
        ST_FILL: begin
          if (fill_valid) begin
            valid_q[idx_q][victim_q] <= 1'b1;
            dirty_q[idx_q][victim_q] <= wr_q;
            resp_valid <= 1'b1;
            resp_hit   <= 1'b0;
            resp_way   <= victim_q;
            resp_data  <= fill_merged[bit_pos +: BYTE_W];
            state_q    <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/vipt_l1_lookup_chk.sv
`timescale 1ns/1ps
module vipt_l1_lookup_chk (
  input logic clk,
  input logic rst,
  input logic req_valid,
  input logic req_ready,
  input logic resp_valid,
  input logic resp_hit,
  input logic fill_req_valid,
  input logic evict_valid,
  input logic fill_valid
);
  logic outstanding_q;

  always_ff @(posedge clk) begin
    if (rst) outstanding_q <= 1'b0;
    else if (req_valid && req_ready) outstanding_q <= 1'b1;
    else if (resp_valid) outstanding_q <= 1'b0;
  end

  // R2: acceptance makes the block busy
  assert_busy_after_accept_R2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  // R2: ready again when the response shows
  assert_ready_with_resp_R2: assert property (@(posedge clk) disable iff (rst)
    resp_valid |-> req_ready);

  // R3: a response only for an accepted, unanswered request
  assert_resp_needs_request_R3: assert property (@(posedge clk) disable iff (rst)
    resp_valid |-> outstanding_q);

  // R5: line request is a single-cycle pulse
  assert_fill_req_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    fill_req_valid |=> !fill_req_valid);

  // R6: a miss answer follows a returned line
  assert_miss_after_fill_R6: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && !resp_hit) |-> $past(fill_valid));

  // R9: write-back only alongside a line request
  assert_evict_with_fill_R9: assert property (@(posedge clk) disable iff (rst)
    evict_valid |-> fill_req_valid);

  // R10: no line request while idle
  assert_no_fill_when_ready_R10: assert property (@(posedge clk) disable iff (rst)
    fill_req_valid |-> !req_ready);
endmodule

bind vipt_l1_lookup vipt_l1_lookup_chk u_chk (.*);

// File: tb/test_vipt_l1_lookup.sv
`timescale 1ns/1ps
module test_vipt_l1_lookup;
  logic         clk = 1'b0;
  logic         rst;
  logic         req_valid, req_ready, req_write;
  logic [11:0]  req_offset;
  logic [7:0]   req_wdata;
  logic         ppn_valid;
  logic [39:0]  ppn;
  logic         resp_valid, resp_hit;
  logic [2:0]   resp_way;
  logic [7:0]   resp_data;
  logic         fill_req_valid, evict_valid, fill_valid;
  logic [45:0]  fill_req_line, evict_line;
  logic [511:0] evict_data, fill_data;

  always #4 clk = ~clk;

  vipt_l1_lookup i_vipt_l1_lookup (.*);

  typedef struct packed {logic hit; logic [2:0] way; logic [7:0] data;} exp_t;
  exp_t  exp_q[$];
  string rq_q[$];
  logic [7:0] shadow [logic [51:0]];
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  task automatic check(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  function automatic logic [511:0] line_image(input logic [45:0] ln);
    logic [511:0] v;
    logic [51:0]  key;
    for (int k = 0; k < 64; k++) begin
      key = {ln, 6'(k)};
      if (shadow.exists(key)) v[k*8 +: 8] = shadow[key];
      else v[k*8 +: 8] = ln[7:0] ^ ln[15:8] ^ 8'(k * 37 + 11);
    end
    return v;
  endfunction

  function automatic logic [39:0] pg(input int i);
    return 40'hC0_FFEE_0000 + 40'(i * 40'h1_0101);
  endfunction

  // Monitor: pops the scoreboard on every response.
  initial begin
    exp_t e;
    string r;
    forever begin
      @(negedge clk);
      if (!rst && resp_valid === 1'b1) begin
        if (exp_q.size() == 0) check(0, "R3 unexpected response", 64'(resp_data), 64'(0));
        else begin
          e = exp_q.pop_front();
          r = rq_q.pop_front();
          check(resp_hit === e.hit && resp_way === e.way && resp_data === e.data, r,
                64'({resp_hit, resp_way, resp_data}), 64'({e.hit, e.way, e.data}));
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    check(0, "watchdog", 64'(0), 64'(1));
    finish_run();
  end

  // Driver: pushes the expected response, drives the access and serves a miss.
  task automatic access(input logic [11:0] off, input bit wr, input logic [7:0] wd,
                        input logic [39:0] p, input int dly, input bit exp_hit,
                        input int exp_way, input bit exp_ev, input logic [45:0] ev_line,
                        input string rq);
    logic [45:0]  ln;
    logic [511:0] img;
    exp_t e;
    ln  = {p, off[11:6]};
    img = line_image(ln);
    e.hit  = exp_hit;
    e.way  = 3'(exp_way);
    e.data = wr ? wd : img[off[5:0]*8 +: 8];
    for (int i = 0; i < 20 && req_ready !== 1'b1; i++) @(negedge clk);
    exp_q.push_back(e);
    rq_q.push_back(rq);
    req_valid = 1; req_offset = off; req_write = wr; req_wdata = wd;
    ppn_valid = (dly == 0); ppn = p;
    @(negedge clk);
    req_valid = 0; ppn_valid = 0;
    if (dly == 0) @(negedge clk);
    else begin
      for (int i = 1; i < dly; i++) begin
        check(resp_valid === 1'b0 && fill_req_valid === 1'b0, "R3 pending without page number",
              64'({resp_valid, fill_req_valid}), 64'(0));
        @(negedge clk);
      end
      ppn_valid = 1; ppn = p;
      @(negedge clk);
      ppn_valid = 0;
    end
    if (exp_hit) begin
      check(resp_valid === 1'b1, "R3 hit response timing", 64'(resp_valid), 64'(1));
    end else begin
      check(fill_req_valid === 1'b1 && fill_req_line === ln, "R5 line request",
            64'(fill_req_line), 64'(ln));
      check(evict_valid === exp_ev, "R9 write-back strobe", 64'(evict_valid), 64'(exp_ev));
      if (exp_ev) begin
        check(evict_line === ev_line, "R9 write-back address", 64'(evict_line), 64'(ev_line));
        check(evict_data === line_image(ev_line), "R9 write-back data",
              evict_data[63:0], line_image(ev_line)[63:0]);
      end
      @(negedge clk);
      fill_valid = 1; fill_data = img;
      @(negedge clk);
      fill_valid = 0;
      check(resp_valid === 1'b1, "R6 response after fill", 64'(resp_valid), 64'(1));
    end
    if (wr) shadow[{ln, off[5:0]}] = wd;
    @(negedge clk);
  endtask

  function automatic logic [11:0] oa(input int set, input int b);
    return {6'(set), 6'(b)};
  endfunction

  initial begin
    rst = 1; req_valid = 0; req_offset = '0; req_write = 0; req_wdata = '0;
    ppn_valid = 0; ppn = '0; fill_valid = 0; fill_data = '0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    check(req_ready === 1'b1 && resp_valid === 1'b0 && fill_req_valid === 1'b0 && evict_valid === 1'b0,
          "R1 reset outputs", 64'({req_ready, resp_valid, fill_req_valid, evict_valid}), 64'(4'b1000));

    // R1 R3 R8: first miss in empty set, late page number, way 0
    access(oa(5, 3), 0, 8'h00, pg(0), 3, 0, 0, 0, '0, "R8 first miss way 0");
    // R4: hit with page number in the acceptance cycle
    access(oa(5, 3), 0, 8'h00, pg(0), 0, 1, 0, 0, '0, "R4 hit read");
    // R7: write hit, then read back
    access(oa(5, 10), 1, 8'h5A, pg(0), 1, 1, 0, 0, '0, "R7 write hit");
    access(oa(5, 10), 0, 8'h00, pg(0), 0, 1, 0, 0, '0, "R7 read back written byte");
    // R8: fill remaining ways in order
    for (int i = 1; i < 8; i++)
      access(oa(5, i), 0, 8'h00, pg(i), 1, 0, i, 0, '0, "R8 invalid way first");
    // R9: full set, LRU way 0 is dirty -> write-back with the line request
    access(oa(5, 20), 0, 8'h00, pg(8), 2, 0, 0, 1, {pg(0), 6'd5}, "R8 LRU victim way 0");
    access(oa(5, 20), 0, 8'h00, pg(8), 0, 1, 0, 0, '0, "R6 refetched line hits");
    // R9: clean LRU victim, no write-back
    access(oa(5, 21), 0, 8'h00, pg(9), 1, 0, 1, 0, '0, "R8 next LRU victim way 1");

    // R10: stray line return while idle
    fill_valid = 1; fill_data = '1;
    @(negedge clk);
    fill_valid = 0;
    check(resp_valid === 1'b0, "R10 stray fill no response", 64'(resp_valid), 64'(0));
    access(oa(5, 0), 0, 8'h00, pg(2), 0, 1, 2, 0, '0, "R10 line unchanged after stray fill");

    // R10: stray page number while idle must not be used
    ppn_valid = 1; ppn = pg(4);
    @(negedge clk);
    ppn_valid = 0;
    access(oa(5, 1), 0, 8'h00, pg(3), 4, 1, 3, 0, '0, "R10 stray page number ignored");

    // R2: boundary offsets, last set last byte and first set first byte
    access(12'hFFF, 0, 8'h00, pg(20), 0, 0, 0, 0, '0, "R2 last set last byte miss");
    access(12'hFFF, 0, 8'h00, pg(20), 1, 1, 0, 0, '0, "R2 last set last byte hit");
    // R7: write-allocate on miss
    access(12'h000, 1, 8'hC3, pg(21), 1, 0, 0, 0, '0, "R7 write miss allocate");
    access(12'h000, 0, 8'h00, pg(21), 0, 1, 0, 0, '0, "R7 read after write miss");

    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R3 all responses seen", 64'(exp_q.size()), 64'(0));
    finish_run();
  end
endmodule